// File: doc/BRIEF.md
# Outstanding-request pool allocator with blocking control

The block tracks two pools of outstanding memory requests: a miss queue (pool 0) and a write buffer (pool 1). An allocation request is steered to one pool by its read/write attributes. The block takes the lowest free slot in that pool and returns the slot identifier, the pool, a global order stamp, and the address and size that the caller should record. A cache-fill miss is widened to a whole aligned block. Any other request keeps its own address and size.

Each pool has a usable threshold and a reserve. It holds `REQ + RES - 1` physical slots and reports itself blocked once `REQ` slots are occupied. The reserve slots still accept requests that are already in flight while the upstream stalls. A per-pool bus-request line stays raised while the pool has work waiting for the memory-side bus. A third blocked cause covers a miss entry that ran out of targets. A third bus-request cause passes an external prefetch request through.

The caller later names an entry by pool and identifier to mark it in service, which means it has been sent on the bus. It names the entry the same way to release it.

Top module: `miss_pool_ctrl`

## Requirements
- R1: A request with write set and read clear goes to pool 1 (write buffer). Every other combination, including read+write and neither, goes to pool 0 (miss queue). The pool is reported on `alloc_pool_o` in the same cycle.
- R2: With `alloc_fill_i`=1 the reported address has its low log2(`BLK_BYTES`) bits cleared and the reported size is `BLK_BYTES` (64 by default). With `alloc_fill_i`=0 the request's own address and size are reported unchanged.
- R3: The identifier granted is the lowest-numbered free slot of the chosen pool. Pool 0 has `MISS_REQ+MISS_RES-1` slots (7 by default). Pool 1 has `WB_REQ+WB_RES-1` slots (4 by default).
- R4: Each accepted allocation is stamped with the current global order count, and the count then increments by one. The first stamp after reset is 0.
- R5: When an allocation brings a pool's occupancy to its `REQ` threshold, that pool's blocked cause is set from the next cycle. Bit 0 of `blocked_o` is pool 0 and bit 1 is pool 1.
- R6: An allocation with `alloc_bus_i`=1 raises the pool's bus request from the next cycle, on `bus_req_o` bit equal to the pool index. An allocation with `alloc_bus_i`=0 leaves it unchanged.
- R7: Marking an entry in service drops that pool's bus request once no pending entry remains. It does not change occupancy, so a blocked pool stays blocked.
- R8: A pool's blocked cause is cleared by a release only when the pool was at or above threshold before the event and is below threshold after it.
- R9: `blocked_o[2]` (no-targets cause) is set by `nt_set_i` for miss entry `nt_id_i`. It is cleared only by a response (`rsp_i`) that names that same entry.
- R10: An allocation to a pool with no free physical slot is ignored. `alloc_ok_o` is 0, no slot is taken, and no order number is consumed.
- R11: `bus_req_o[2]` follows the prefetch input `pf_req_i` in the same cycle. `bus_req_any_o` is the OR of all three request causes.
- R12: After reset no cause is blocked, no bus request is raised, and all slots are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_i | input | 1 | Allocation request |
| alloc_wr_i | input | 1 | Request writes |
| alloc_rd_i | input | 1 | Request reads |
| alloc_fill_i | input | 1 | Request is a cache-fill miss (whole block) |
| alloc_bus_i | input | 1 | Raise the pool bus request on allocation |
| alloc_addr_i | input | AW | Request address |
| alloc_size_i | input | SZ_W | Request size in bytes |
| alloc_ok_o | output | 1 | Allocation accepted this cycle |
| alloc_pool_o | output | 1 | Pool chosen (0 miss, 1 write buffer) |
| alloc_id_o | output | ID_W | Slot granted |
| alloc_order_o | output | ORD_W | Order stamp of this allocation |
| alloc_eaddr_o | output | AW | Address to record for the entry |
| alloc_esize_o | output | SZ_W | Size to record for the entry |
| svc_i | input | 1 | Mark entry in service |
| svc_pool_i | input | 1 | Pool of the entry put in service |
| svc_id_i | input | ID_W | Slot put in service |
| rel_i | input | 1 | Release entry |
| rel_pool_i | input | 1 | Pool of released entry |
| rel_id_i | input | ID_W | Slot released |
| nt_set_i | input | 1 | Miss entry ran out of targets |
| nt_id_i | input | ID_W | Miss slot that ran out of targets |
| rsp_i | input | 1 | Response arrived for a miss entry |
| rsp_id_i | input | ID_W | Miss slot of the response |
| pf_req_i | input | 1 | Prefetch bus-request cause |
| blocked_o | output | 3 | Blocked causes: miss, write buffer, no targets |
| bus_req_o | output | 3 | Bus-request causes: miss, write buffer, prefetch |
| bus_req_any_o | output | 1 | Any bus request |

## Verification
The assertions assume well-formed events. A mark-in-service names a valid, still-pending slot. A release names a valid slot. Identifiers stay inside the named pool's range. The stimulus only ever marks or releases slots that it was granted earlier and has not yet released, and it keeps a slot from being put in service twice. Overfilling a pool is intended stimulus, and the assertions expect it to leave slot state untouched. The bench provokes it on purpose in both pools.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int unsigned POOL_MISS = 0;
  localparam int unsigned POOL_WB   = 1;
  localparam int unsigned CAUSE_NT  = 2;  // no-targets blocked cause
  localparam int unsigned CAUSE_PF  = 2;  // prefetch bus-request cause
  localparam int unsigned N_CAUSE   = 3;
endpackage

// File: rtl/slot_pick.sv
module slot_pick #(
  parameter int unsigned N    = 4,
  parameter int unsigned ID_W = 2
) (
  input  logic [N-1:0]    used_i,
  output logic            has_o,
  output logic [ID_W-1:0] idx_o
);
  always_comb begin
    has_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!used_i[i]) begin
        has_o = 1'b1;
        idx_o = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/pool_track.sv
module pool_track #(
  parameter int unsigned N    = 4,
  parameter int unsigned REQ  = 4,
  parameter int unsigned ID_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            alloc_i,
  input  logic            bus_i,
  input  logic            svc_i,
  input  logic [ID_W-1:0] svc_id_i,
  input  logic            rel_i,
  input  logic [ID_W-1:0] rel_id_i,
  output logic            has_free_o,
  output logic [ID_W-1:0] pick_o,
  output logic            blocked_o,
  output logic            breq_o
);
  logic [N-1:0] valid_q, pend_q, valid_d, pend_d;
  logic [N-1:0] a_oh, s_oh, r_oh;
  logic         alloc_fire, svc_fire, rel_fire;
  logic         full_b, full_a;
  logic         blk_q, blk_d, breq_q, breq_d;

  slot_pick #(.N(N), .ID_W(ID_W)) u_pick (
    .used_i(valid_q),
    .has_o (has_free_o),
    .idx_o (pick_o)
  );

  assign alloc_fire = alloc_i && has_free_o;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      a_oh[i] = alloc_fire && (pick_o == ID_W'(i));
      s_oh[i] = svc_i && (svc_id_i == ID_W'(i)) && valid_q[i] && pend_q[i];
      r_oh[i] = rel_i && (rel_id_i == ID_W'(i)) && valid_q[i];
    end
  end

  assign svc_fire = |s_oh;
  assign rel_fire = |r_oh;
  assign valid_d  = (valid_q & ~r_oh) | a_oh;
  assign pend_d   = (pend_q & ~s_oh & ~r_oh) | a_oh;
  assign full_b   = $countones(valid_q) >= REQ;
  assign full_a   = $countones(valid_d) >= REQ;

  always_comb begin
    blk_d = blk_q;
    if (alloc_fire && full_a)   blk_d = 1'b1;
    else if (full_b && !full_a) blk_d = 1'b0;
  end

  always_comb begin
    breq_d = breq_q;
    if (alloc_fire && bus_i)            breq_d = 1'b1;
    else if (svc_fire && pend_d == '0)  breq_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      pend_q  <= '0;
      blk_q   <= 1'b0;
      breq_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      pend_q  <= pend_d;
      blk_q   <= blk_d;
      breq_q  <= breq_d;
    end
  end

  assign blocked_o = blk_q;
  assign breq_o    = breq_q;

  // R3: granted slot was free
  a_r3_pick_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_fire |-> (valid_q & a_oh) == '0);
  // R10: no free slot, no release -> slot state untouched
  a_r10_reject_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !has_free_o && !rel_fire) |=> $stable(valid_q));
  // R5: reaching threshold by allocation blocks
  a_r5_block_on_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_fire && !rel_fire && $countones(valid_q) == REQ - 1) |=> blk_q);
  // R7: last pending entry served drops the request
  a_r7_breq_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_fire && !alloc_fire && $countones(pend_q) == 1) |=> !breq_q);
  // R7: service alone keeps blocked state
  a_r7_svc_keeps_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_fire && !alloc_fire && !rel_fire) |=> $stable(blk_q));
  // R8: leaving threshold by release unblocks
  a_r8_unblock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_fire && !alloc_fire && $countones(valid_q) == REQ) |=> !blk_q);
endmodule

// File: rtl/miss_pool_ctrl.sv
module miss_pool_ctrl
  import mpc_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned BLK_BYTES = 64,
  parameter int unsigned MISS_REQ  = 4,
  parameter int unsigned MISS_RES  = 4,
  parameter int unsigned WB_REQ    = 4,
  parameter int unsigned WB_RES    = 1,
  parameter int unsigned ORD_W     = 16,
  localparam int unsigned MISS_N   = MISS_REQ + MISS_RES - 1,
  localparam int unsigned WB_N     = WB_REQ + WB_RES - 1,
  localparam int unsigned MAX_N    = (MISS_N > WB_N) ? MISS_N : WB_N,
  localparam int unsigned ID_W     = (MAX_N > 1) ? $clog2(MAX_N) : 1,
  localparam int unsigned OFF_W    = $clog2(BLK_BYTES),
  localparam int unsigned SZ_W     = OFF_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             alloc_wr_i,
  input  logic             alloc_rd_i,
  input  logic             alloc_fill_i,
  input  logic             alloc_bus_i,
  input  logic [AW-1:0]    alloc_addr_i,
  input  logic [SZ_W-1:0]  alloc_size_i,
  output logic             alloc_ok_o,
  output logic             alloc_pool_o,
  output logic [ID_W-1:0]  alloc_id_o,
  output logic [ORD_W-1:0] alloc_order_o,
  output logic [AW-1:0]    alloc_eaddr_o,
  output logic [SZ_W-1:0]  alloc_esize_o,
  input  logic             svc_i,
  input  logic             svc_pool_i,
  input  logic [ID_W-1:0]  svc_id_i,
  input  logic             rel_i,
  input  logic             rel_pool_i,
  input  logic [ID_W-1:0]  rel_id_i,
  input  logic             nt_set_i,
  input  logic [ID_W-1:0]  nt_id_i,
  input  logic             rsp_i,
  input  logic [ID_W-1:0]  rsp_id_i,
  input  logic             pf_req_i,
  output logic [N_CAUSE-1:0] blocked_o,
  output logic [N_CAUSE-1:0] bus_req_o,
  output logic             bus_req_any_o
);
  logic             sel;
  logic [1:0]       has_free, blk, breq;
  logic [ID_W-1:0]  pick [2];
  logic [ORD_W-1:0] ord_q;
  logic             nt_q;
  logic [ID_W-1:0]  nt_id_q;

  // write-only requests go to the write buffer
  assign sel = alloc_wr_i && !alloc_rd_i;

  for (genvar p = 0; p < 2; p++) begin : g_pool
    localparam int unsigned PN   = (p == POOL_MISS) ? MISS_N : WB_N;
    localparam int unsigned PREQ = (p == POOL_MISS) ? MISS_REQ : WB_REQ;
    pool_track #(.N(PN), .REQ(PREQ), .ID_W(ID_W)) u_pool (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .alloc_i   (alloc_i && (sel == 1'(p))),
      .bus_i     (alloc_bus_i),
      .svc_i     (svc_i && (svc_pool_i == 1'(p))),
      .svc_id_i  (svc_id_i),
      .rel_i     (rel_i && (rel_pool_i == 1'(p))),
      .rel_id_i  (rel_id_i),
      .has_free_o(has_free[p]),
      .pick_o    (pick[p]),
      .blocked_o (blk[p]),
      .breq_o    (breq[p])
    );
  end

  assign alloc_ok_o    = alloc_i && has_free[sel];
  assign alloc_pool_o  = sel;
  assign alloc_id_o    = pick[sel];
  assign alloc_order_o = ord_q;
  assign alloc_eaddr_o = alloc_fill_i ? {alloc_addr_i[AW-1:OFF_W], {OFF_W{1'b0}}}
                                      : alloc_addr_i;
  assign alloc_esize_o = alloc_fill_i ? SZ_W'(BLK_BYTES) : alloc_size_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ord_q   <= '0;
      nt_q    <= 1'b0;
      nt_id_q <= '0;
    end else begin
      if (alloc_ok_o) ord_q <= ord_q + 1'b1;
      if (nt_set_i) begin
        nt_q    <= 1'b1;
        nt_id_q <= nt_id_i;
      end else if (rsp_i && nt_q && (rsp_id_i == nt_id_q)) begin
        nt_q <= 1'b0;
      end
    end
  end

  assign blocked_o     = {nt_q, blk[POOL_WB], blk[POOL_MISS]};
  assign bus_req_o     = {pf_req_i, breq[POOL_WB], breq[POOL_MISS]};
  assign bus_req_any_o = |bus_req_o;

  // R4: order advances by one per accepted allocation
  a_r4_order_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_ok_o |=> alloc_order_o == ORD_W'($past(alloc_order_o) + 1'b1));
  // R10: rejected allocation consumes no order number
  a_r10_order_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alloc_ok_o |=> $stable(alloc_order_o));
  // R9: matching response clears the no-targets cause
  a_r9_nt_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blocked_o[CAUSE_NT] && rsp_i && rsp_id_i == nt_id_q && !nt_set_i)
      |=> !blocked_o[CAUSE_NT]);
endmodule

// File: tb/sim_miss_pool_ctrl.sv
`timescale 1ns/1ps
module sim_miss_pool_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        alloc_i = 0, alloc_wr_i = 0, alloc_rd_i = 0, alloc_fill_i = 0, alloc_bus_i = 0;
  logic [31:0] alloc_addr_i = '0;
  logic [6:0]  alloc_size_i = '0;
  logic        alloc_ok_o, alloc_pool_o;
  logic [2:0]  alloc_id_o;
  logic [15:0] alloc_order_o;
  logic [31:0] alloc_eaddr_o;
  logic [6:0]  alloc_esize_o;
  logic        svc_i = 0, svc_pool_i = 0, rel_i = 0, rel_pool_i = 0;
  logic [2:0]  svc_id_i = '0, rel_id_i = '0, nt_id_i = '0, rsp_id_i = '0;
  logic        nt_set_i = 0, rsp_i = 0, pf_req_i = 0;
  logic [2:0]  blocked_o, bus_req_o;
  logic        bus_req_any_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  miss_pool_ctrl u0 (.*);

  typedef struct packed {
    logic        wr, rd, fill, rbus;
    logic [31:0] addr;
    logic [6:0]  size;
    logic        pool;
    logic [2:0]  id;
    logic [15:0] ord;
    logic [31:0] eaddr;
    logic [6:0]  esize;
    logic [1:0]  ebreq, eblk;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0,1'b1,1'b1,1'b0,32'h1234,7'd8, 1'b0,3'd0,16'd0,32'h1200,7'd64,2'b00,2'b00},
    '{1'b1,1'b0,1'b0,1'b1,32'h2008,7'd4, 1'b1,3'd0,16'd1,32'h2008,7'd4, 2'b10,2'b00},
    '{1'b1,1'b1,1'b1,1'b1,32'h3045,7'd8, 1'b0,3'd1,16'd2,32'h3040,7'd64,2'b11,2'b00},
    '{1'b0,1'b1,1'b0,1'b0,32'h4003,7'd2, 1'b0,3'd2,16'd3,32'h4003,7'd2, 2'b11,2'b00},
    '{1'b1,1'b0,1'b0,1'b1,32'h5000,7'd64,1'b1,3'd1,16'd4,32'h5000,7'd64,2'b11,2'b00},
    '{1'b0,1'b0,1'b1,1'b1,32'h6010,7'd8, 1'b0,3'd3,16'd5,32'h6000,7'd64,2'b11,2'b01}
  };

  logic        s_ok, s_pool;
  logic [2:0]  s_id;
  logic [15:0] s_ord;
  logic [31:0] s_addr;
  logic [6:0]  s_size;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_alloc(input logic wr, rd, fill, rbus, input logic [31:0] a, input logic [6:0] sz);
    @(negedge clk_i);
    alloc_i = 1; alloc_wr_i = wr; alloc_rd_i = rd; alloc_fill_i = fill;
    alloc_bus_i = rbus; alloc_addr_i = a; alloc_size_i = sz;
    #1;
    s_ok = alloc_ok_o; s_pool = alloc_pool_o; s_id = alloc_id_o;
    s_ord = alloc_order_o; s_addr = alloc_eaddr_o; s_size = alloc_esize_o;
    @(negedge clk_i);
    alloc_i = 0;
  endtask

  task automatic do_svc(input logic p, input logic [2:0] id);
    @(negedge clk_i); svc_i = 1; svc_pool_i = p; svc_id_i = id;
    @(negedge clk_i); svc_i = 0;
  endtask

  task automatic do_rel(input logic p, input logic [2:0] id);
    @(negedge clk_i); rel_i = 1; rel_pool_i = p; rel_id_i = id;
    @(negedge clk_i); rel_i = 0;
  endtask

  task automatic do_nt(input logic [2:0] id);
    @(negedge clk_i); nt_set_i = 1; nt_id_i = id;
    @(negedge clk_i); nt_set_i = 0;
  endtask

  task automatic do_rsp(input logic [2:0] id);
    @(negedge clk_i); rsp_i = 1; rsp_id_i = id;
    @(negedge clk_i); rsp_i = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R12 reset state
    chk("R12 blocked", 64'(blocked_o), 64'd0);
    chk("R12 bus_req", 64'(bus_req_o), 64'd0);
    chk("R12 any", 64'(bus_req_any_o), 64'd0);

    foreach (VECS[k]) begin
      do_alloc(VECS[k].wr, VECS[k].rd, VECS[k].fill, VECS[k].rbus, VECS[k].addr, VECS[k].size);
      chk("R10 ok", 64'(s_ok), 64'd1);
      chk("R1 pool", 64'(s_pool), 64'(VECS[k].pool));
      chk("R3 id", 64'(s_id), 64'(VECS[k].id));
      chk("R4 order", 64'(s_ord), 64'(VECS[k].ord));
      chk("R2 addr", 64'(s_addr), 64'(VECS[k].eaddr));
      chk("R2 size", 64'(s_size), 64'(VECS[k].esize));
      chk("R6 bus_req", 64'(bus_req_o[1:0]), 64'(VECS[k].ebreq));
      chk("R5 blocked", 64'(blocked_o[1:0]), 64'(VECS[k].eblk));
    end

    // reserve slots still accept while blocked
    for (int i = 4; i < 7; i++) begin
      do_alloc(0, 1, 1, 1, 32'h7000, 7'd8);
      chk("R3 reserve ok", 64'(s_ok), 64'd1);
      chk("R3 reserve id", 64'(s_id), 64'(i));
      chk("R4 reserve order", 64'(s_ord), 64'(i + 2));
    end
    do_alloc(0, 1, 1, 1, 32'h7100, 7'd8);
    chk("R10 miss exhausted", 64'(s_ok), 64'd0);
    chk("R5 still blocked", 64'(blocked_o[0]), 64'd1);
    do_rel(0, 3'd2);
    chk("R8 no unblock above threshold", 64'(blocked_o[0]), 64'd1);
    do_alloc(0, 1, 0, 1, 32'h7200, 7'd4);
    chk("R3 lowest freed id", 64'(s_id), 64'd2);
    chk("R10 order not consumed", 64'(s_ord), 64'd9);

    for (int i = 0; i < 6; i++) do_svc(0, 3'(i));
    chk("R7 pending remain", 64'(bus_req_o[0]), 64'd1);
    do_svc(0, 3'd6);
    chk("R7 last pending drops", 64'(bus_req_o[0]), 64'd0);
    chk("R7 service keeps blocked", 64'(blocked_o[0]), 64'd1);

    for (int i = 0; i < 3; i++) do_rel(0, 3'(i));
    chk("R8 at threshold", 64'(blocked_o[0]), 64'd1);
    do_rel(0, 3'd3);
    chk("R8 unblock miss", 64'(blocked_o[0]), 64'd0);

    do_alloc(1, 0, 0, 1, 32'h8000, 7'd4);
    chk("R3 wb id", 64'(s_id), 64'd2);
    chk("R4 wb order", 64'(s_ord), 64'd10);
    chk("R5 wb not yet", 64'(blocked_o[1]), 64'd0);
    do_alloc(1, 0, 0, 1, 32'h8004, 7'd4);
    chk("R5 wb blocked", 64'(blocked_o[1]), 64'd1);
    do_alloc(1, 0, 0, 1, 32'h8008, 7'd4);
    chk("R10 wb exhausted", 64'(s_ok), 64'd0);
    do_svc(1, 3'd1);
    chk("R7 wb pending remain", 64'(bus_req_o[1]), 64'd1);
    do_rel(1, 3'd0);
    chk("R8 unblock wb", 64'(blocked_o[1]), 64'd0);

    do_nt(3'd5);
    chk("R9 set", 64'(blocked_o[2]), 64'd1);
    do_rsp(3'd4);
    chk("R9 other id keeps", 64'(blocked_o[2]), 64'd1);
    do_rsp(3'd5);
    chk("R9 matching clears", 64'(blocked_o[2]), 64'd0);

    @(negedge clk_i);
    chk("R11 pf low", 64'(bus_req_o[2]), 64'd0);
    pf_req_i = 1; #1;
    chk("R11 pf high", 64'(bus_req_o[2]), 64'd1);
    chk("R11 any", 64'(bus_req_any_o), 64'd1);
    pf_req_i = 0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule